// File: doc/BRIEF.md
# Multiplexed-Bus I/O Target Responder

This block is a target-only responder for a synchronous 32-bit bus that carries the address and the data on the same wires. It answers single and burst I/O read and I/O write transactions aimed at one parameterised four-byte window. A write places the bus data into an output latch. A read returns the value present on an input port. The block never starts a transaction of its own.

The active-low bus controls are modelled as a driven value plus an output enable for each line. These lines are the target-select acknowledge, the target-ready line and the AD bus. A pad ring outside the block turns each pair into a three-state pin. When a transaction ends, the block first drives its acknowledge lines high for one clock and then releases them, so the shared lines are left high. It drives AD only during read data phases, after one turnaround clock.

A five-state control machine sequences the response. The state values are fixed: 4 is idle, 0 is busy with a transaction for another agent, 2 is write, 5 is read and 3 is terminating. From the terminating state, a new hit transaction goes straight into read or write without passing through idle.

Top module: `mux_bus_io_target`

## Requirements
- R1: After an active-low synchronous reset, every output enable (select acknowledge, ready, AD) is 0 and the output latch reads 0.
- R2: A transaction is recognised on the first clock edge in idle at which frameN is sampled 0. It is a hit when adIn[31:2] equals BASE_ADDR[31:2]. adIn[1:0] is ignored. The command cbeN = 4'b0011 is an I/O write and cbeN = 4'b0010 is an I/O read.
- R3: After a write hit, devselOe and trdyOe are 1 and devselOut and trdyOut are 0 from the cycle after the address edge until the last data phase.
- R4: During a write, adIn is stored into latchOut on each edge where irdyN is 0. While irdyN is 1 (wait states) the latch is unchanged and the target keeps waiting.
- R5: A data phase with frameN = 1 is the last one. The following cycle drives devselOut and trdyOut high with their enables at 1. The cycle after that releases both enables to 0, unless a new hit starts.
- R6: After a read hit, the first cycle is a turnaround in which nothing is driven. In the second cycle devsel and trdy are driven low and adOe is 1. In that cycle adOut equals the portIn value sampled at the end of the turnaround cycle.
- R7: A read data phase completes on an edge where irdyN is 0 while the target is driving. When frameN is 1 at that edge, adOe drops to 0 in the same cycle that devselOut is driven high.
- R8: A cycle whose address misses, or whose command is neither I/O read nor I/O write, gets no response. The machine then waits for an edge with frameN and irdyN both 1. Any address or command seen while it waits is ignored, even one that would hit.
- R9: A hit transaction that starts in the terminating cycle (fast back-to-back) is accepted directly. A write drives devsel low in the very next cycle. A read enters its turnaround cycle.
- R10: While frameN stays 0 across completed data phases (a burst), the target stays in the data state. Each write phase updates the latch, and each read phase presents the port value sampled at the previous completed phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | Transaction framing, active low |
| irdyN | input | 1 | Initiator ready, active low |
| cbeN | input | 4 | Command during address phase, byte enables afterwards |
| adIn | input | 32 | Sampled value of the AD bus |
| adOut | output | 32 | Read data driven onto AD |
| adOe | output | 1 | Enable for adOut |
| devselOut | output | 1 | Value driven on the select acknowledge line |
| devselOe | output | 1 | Enable for the select acknowledge line |
| trdyOut | output | 1 | Value driven on the target ready line |
| trdyOe | output | 1 | Enable for the target ready line |
| portIn | input | 32 | Input port returned by reads |
| latchOut | output | 32 | Output latch written by writes |

## Verification
The hardest case to reach from the ports is the terminating cycle being immediately reused by another hit. This fast back-to-back case needs the initiator to raise a new frame exactly one clock after the last data phase. The bench reaches it with a directed write-then-read and write-then-write chain. Its random loop also chooses, after every hit transaction, whether to skip the idle clock. A second hard case is a hit address that appears while the machine is waiting out a foreign transaction. A directed sequence keeps frameN low across a miss and then presents the device's own address and command.

// File: rtl/io_tgt_pkg.sv
package io_tgt_pkg;
  typedef enum logic [2:0] {
    ST_BUSY  = 3'd0,
    ST_WRITE = 3'd2,
    ST_TERM  = 3'd3,
    ST_IDLE  = 3'd4,
    ST_READ  = 3'd5
  } tgtState_e;

  typedef struct packed {
    logic latchWr;
    logic rdCapture;
  } dpStrobe_t;

  typedef struct packed {
    logic hitRd;
    logic hitWr;
  } decode_t;
endpackage

// File: rtl/io_tgt_datapath.sv
module io_tgt_datapath
  import io_tgt_pkg::*;
#(
  parameter int          AD_W      = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0000_0300,
  parameter logic [3:0]  CMD_RD    = 4'b0010,
  parameter logic [3:0]  CMD_WR    = 4'b0011
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AD_W-1:0] adIn,
  input  logic [3:0]      cbeN,
  input  logic [AD_W-1:0] portIn,
  input  dpStrobe_t       strobe,
  output decode_t         dec,
  output logic [AD_W-1:0] latchOut,
  output logic [AD_W-1:0] rdData
);
  localparam int DEC_LO = 2;

  logic baseMatch;
  assign baseMatch = (adIn[AD_W-1:DEC_LO] == BASE_ADDR[AD_W-1:DEC_LO]);

  always_comb begin
    dec.hitRd = baseMatch && (cbeN == CMD_RD);
    dec.hitWr = baseMatch && (cbeN == CMD_WR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchOut <= '0;
      rdData   <= '0;
    end else begin
      if (strobe.latchWr)   latchOut <= adIn;
      if (strobe.rdCapture) rdData   <= portIn;
    end
  end
endmodule

// File: rtl/io_tgt_control.sv
module io_tgt_control
  import io_tgt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameN,
  input  logic      irdyN,
  input  decode_t   dec,
  output dpStrobe_t strobe,
  output logic      devselOut,
  output logic      devselOe,
  output logic      trdyOut,
  output logic      trdyOe,
  output logic      adOe
);
  tgtState_e state, stateNext;
  logic      rdReady;
  logic      startFrame;
  tgtState_e startTarget;

  assign startFrame  = !frameN;
  assign startTarget = dec.hitWr ? ST_WRITE : (dec.hitRd ? ST_READ : ST_BUSY);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startFrame) stateNext = startTarget;
      ST_BUSY:  if (frameN && irdyN) stateNext = ST_IDLE;
      ST_WRITE: if (!irdyN && frameN) stateNext = ST_TERM;
      ST_READ:  if (rdReady && !irdyN && frameN) stateNext = ST_TERM;
      ST_TERM:  stateNext = startFrame ? startTarget : ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rdReady <= 1'b0;
    end else begin
      state   <= stateNext;
      rdReady <= (state == ST_READ) && (stateNext == ST_READ);
    end
  end

  logic driveLow, driveHigh;
  always_comb begin
    driveLow  = (state == ST_WRITE) || ((state == ST_READ) && rdReady);
    driveHigh = (state == ST_TERM);
    devselOe  = driveLow || driveHigh;
    trdyOe    = driveLow || driveHigh;
    devselOut = driveHigh;
    trdyOut   = driveHigh;
    adOe      = (state == ST_READ) && rdReady;
    strobe.latchWr   = (state == ST_WRITE) && !irdyN;
    strobe.rdCapture = (state == ST_READ) && (!rdReady || (!irdyN && !frameN));
  end
endmodule

// File: rtl/mux_bus_io_target.sv
module mux_bus_io_target
  import io_tgt_pkg::*;
#(
  parameter int          AD_W      = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0000_0300,
  parameter logic [3:0]  CMD_RD    = 4'b0010,
  parameter logic [3:0]  CMD_WR    = 4'b0011
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameN,
  input  logic            irdyN,
  input  logic [3:0]      cbeN,
  input  logic [AD_W-1:0] adIn,
  output logic [AD_W-1:0] adOut,
  output logic            adOe,
  output logic            devselOut,
  output logic            devselOe,
  output logic            trdyOut,
  output logic            trdyOe,
  input  logic [AD_W-1:0] portIn,
  output logic [AD_W-1:0] latchOut
);
  dpStrobe_t strobe;
  decode_t   dec;

  io_tgt_control ctrl_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .dec(dec),
    .strobe(strobe), .devselOut(devselOut), .devselOe(devselOe),
    .trdyOut(trdyOut), .trdyOe(trdyOe), .adOe(adOe)
  );

  io_tgt_datapath #(
    .AD_W(AD_W), .BASE_ADDR(BASE_ADDR), .CMD_RD(CMD_RD), .CMD_WR(CMD_WR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cbeN(cbeN), .portIn(portIn),
    .strobe(strobe), .dec(dec), .latchOut(latchOut), .rdData(adOut)
  );
endmodule

// File: rtl/io_tgt_checker.sv
module io_tgt_checker #(
  parameter int AD_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            irdyN,
  input logic            adOe,
  input logic            devselOut,
  input logic            devselOe,
  input logic            trdyOut,
  input logic            trdyOe,
  input logic [AD_W-1:0] latchOut
);
  // R7: AD is driven only while the select acknowledge is driven low
  p_ad_under_devsel_r7: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (devselOe && !devselOut));

  // R3: ready line follows the select acknowledge line
  p_trdy_tracks_devsel_r3: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOe == devselOe) && (!trdyOe || (trdyOut == devselOut)));

  // R5: a high drive lasts one clock only
  p_high_one_clock_r5: assert property (@(posedge clk) disable iff (!rstN)
    (devselOe && devselOut) |=> (!devselOe || !devselOut));

  // R4: no latch change across an edge with irdyN high
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    irdyN |=> $stable(latchOut));
endmodule

bind mux_bus_io_target io_tgt_checker #(.AD_W(AD_W)) chk_i (
  .clk(clk), .rstN(rstN), .irdyN(irdyN), .adOe(adOe),
  .devselOut(devselOut), .devselOe(devselOe), .trdyOut(trdyOut),
  .trdyOe(trdyOe), .latchOut(latchOut)
);

// File: tb/mux_bus_io_target_tb.sv
`timescale 1ns/1ps
module mux_bus_io_target_tb_top;
  localparam logic [31:0] BASE = 32'h0000_0300;
  localparam logic [3:0]  C_RD = 4'b0010;
  localparam logic [3:0]  C_WR = 4'b0011;

  logic clk = 1'b0;
  logic rstN, frameN, irdyN;
  logic [3:0]  cbeN;
  logic [31:0] adIn, adOut, portIn, latchOut;
  logic adOe, devselOut, devselOe, trdyOut, trdyOe;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expLatch;

  always #5 clk = ~clk;

  mux_bus_io_target #(.BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN),
    .adIn(adIn), .adOut(adOut), .adOe(adOe), .devselOut(devselOut),
    .devselOe(devselOe), .trdyOut(trdyOut), .trdyOe(trdyOe),
    .portIn(portIn), .latchOut(latchOut)
  );

  function automatic logic isHit(logic [31:0] a, logic [3:0] c, logic [3:0] want);
    return (a[31:2] == BASE[31:2]) && (c == want);
  endfunction

  // encodes {devselOe, devselOut, trdyOe, trdyOut, adOe}
  function automatic logic [4:0] ctl(logic oe, logic hi, logic ad);
    return {oe, hi, oe, hi, ad};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ctlNow();
    return {27'd0, devselOe, devselOut, trdyOe, trdyOut, adOe};
  endfunction

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic busIdle();
    frameN = 1'b1; irdyN = 1'b1; cbeN = 4'hF; adIn = '0;
  endtask

  task automatic doWrite(logic [31:0] a, logic [3:0] c, logic [31:0] d, int waits, bit b2b);
    bit hit = isHit(a, c, C_WR);
    frameN = 1'b0; irdyN = 1'b1; cbeN = c; adIn = a;
    tick();
    chk("R3 write select low", ctlNow(), hit ? ctl(1, 0, 0) : ctl(0, 0, 0));
    cbeN = 4'h0; adIn = d;
    for (int w = 0; w < waits; w++) begin
      frameN = 1'b1; irdyN = 1'b1;
      tick();
      chk("R4 wait state latch held", latchOut, expLatch);
    end
    frameN = 1'b1; irdyN = 1'b0;
    tick();
    if (hit) expLatch = d;
    chk("R4 write data latched", latchOut, expLatch);
    chk("R5 terminate drives high", ctlNow(), hit ? ctl(1, 1, 0) : ctl(0, 0, 0));
    busIdle();
    if (!b2b || !hit) begin
      tick();
      chk("R5 release after high", ctlNow(), ctl(0, 0, 0));
    end
  endtask

  task automatic doRead(logic [31:0] a, logic [3:0] c, logic [31:0] pv, bit b2b);
    bit hit = isHit(a, c, C_RD);
    frameN = 1'b0; irdyN = 1'b1; cbeN = c; adIn = a;
    tick();
    chk("R6 turnaround nothing driven", ctlNow(), ctl(0, 0, 0));
    portIn = pv; frameN = 1'b1; irdyN = 1'b0; cbeN = 4'h0; adIn = '0;
    tick();
    chk("R6 read drive", ctlNow(), hit ? ctl(1, 0, 1) : ctl(0, 0, 0));
    if (hit) chk("R6 read data", adOut, pv);
    portIn = ~pv;
    tick();
    chk("R7 adOe drops with high drive", ctlNow(), hit ? ctl(1, 1, 0) : ctl(0, 0, 0));
    busIdle();
    if (!b2b || !hit) begin
      tick();
      chk("R5 release after read", ctlNow(), ctl(0, 0, 0));
    end
  endtask

  initial begin
    #1_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    expLatch = '0;
    portIn = '0;
    busIdle();
    rstN = 1'b0;
    tick(); tick();
    chk("R1 reset enables", ctlNow(), ctl(0, 0, 0));
    chk("R1 reset latch", latchOut, 32'd0);
    rstN = 1'b1;
    tick();

    // R2 R3 R4 R5: single hit write, low address bits ignored
    doWrite(BASE | 32'h3, C_WR, 32'hA5A5_0001, 0, 0);
    doWrite(BASE, C_WR, 32'h1234_5678, 2, 0);
    // R8: misses of address and of command
    doWrite(BASE ^ 32'h0000_1000, C_WR, 32'hDEAD_BEEF, 0, 0);
    doWrite(BASE, 4'b0111, 32'hDEAD_0001, 0, 0);
    doRead(BASE, C_WR ^ 4'b0100, 32'h5555_0000, 0);
    // R6 R7: read hit
    doRead(BASE | 32'h1, C_RD, 32'hCAFE_F00D, 0);
    // R9: fast back-to-back write->read->write->write
    doWrite(BASE, C_WR, 32'h0000_00B1, 0, 1);
    doRead(BASE, C_RD, 32'h0BAD_0001, 1);
    doWrite(BASE, C_WR, 32'h0000_00B2, 1, 1);
    doWrite(BASE, C_WR, 32'h0000_00B3, 0, 0);

    // R8: hit address shown while waiting out a foreign transaction
    frameN = 1'b0; irdyN = 1'b1; cbeN = 4'b0110; adIn = BASE;
    tick();
    cbeN = C_WR; adIn = BASE; irdyN = 1'b0;
    tick();
    chk("R8 busy ignores hit", ctlNow(), ctl(0, 0, 0));
    frameN = 1'b1; adIn = 32'hFFFF_0000;
    tick();
    chk("R8 busy latch untouched", latchOut, expLatch);
    chk("R8 busy no drive", ctlNow(), ctl(0, 0, 0));
    busIdle();
    tick();

    // R10: burst write of three phases
    frameN = 1'b0; irdyN = 1'b1; cbeN = C_WR; adIn = BASE;
    tick();
    for (int p = 0; p < 3; p++) begin
      frameN = (p == 2); irdyN = 1'b0; cbeN = 4'h0; adIn = 32'h7000_0000 + p;
      tick();
      expLatch = 32'h7000_0000 + p;
      chk("R10 burst write phase", latchOut, expLatch);
      chk("R10 burst state", ctlNow(), (p == 2) ? ctl(1, 1, 0) : ctl(1, 0, 0));
    end
    busIdle();
    tick();

    // R10: burst read of two phases
    frameN = 1'b0; irdyN = 1'b1; cbeN = C_RD; adIn = BASE;
    tick();
    portIn = 32'h1111_0000; frameN = 1'b0; irdyN = 1'b0; cbeN = 4'h0;
    tick();
    chk("R10 burst read first", adOut, 32'h1111_0000);
    portIn = 32'h2222_0000;
    tick();
    chk("R10 burst read stays", ctlNow(), ctl(1, 0, 1));
    chk("R10 burst read second", adOut, 32'h2222_0000);
    frameN = 1'b1; portIn = 32'h3333_0000;
    tick();
    chk("R7 burst read end", ctlNow(), ctl(1, 1, 0));
    busIdle();
    tick();

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      logic [3:0]  c;
      int kind = $urandom_range(0, 3);
      bit b2b = $urandom_range(0, 1);
      a = ($urandom_range(0, 2) != 0) ? (BASE | $urandom_range(0, 3))
                                       : (BASE ^ (32'd1 << $urandom_range(2, 31)));
      if (kind == 0) c = C_RD;
      else if (kind == 1) c = C_WR;
      else c = (kind == 2) ? C_WR : 4'b0110;
      if (kind == 0) doRead(a, c, $urandom, b2b);
      else doWrite(a, c, $urandom, $urandom_range(0, 2), b2b);
    end
    busIdle();
    tick();
    chk("R5 final release", ctlNow(), ctl(0, 0, 0));
    chk("R4 final latch", latchOut, expLatch);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule